// File: doc/BRIEF.md
# Byte-Wide Configuration Port Receiver

This block sits on the target side of a byte-wide configuration port. At every rising clock edge it samples an active-low select, an active-low write strobe and an 8-bit data bus. A byte is taken only when the host is writing and the receiver is not busy. Accepted bytes go into a small buffer and leave through a valid/ready stream towards the downstream configuration logic. When that buffer is full, a registered busy flag tells the host to keep the current byte on the bus until busy drops.

A configuration packet may be split over several select windows. The outgoing stream therefore runs on across select gaps as if the windows were one. If the host changes the write level while select stays asserted over two sampled edges, the receiver treats this as a protocol violation. It raises a one-cycle abort pulse, discards what it has buffered, and takes no more bytes until select has been released and asserted again. Cycles with select low and write high are readback cycles: they carry no write data, and returning readback data is outside this block.

Top module: `cfg_port_rx`

## Requirements
- R1: At a rising edge where `sel_n`=0, `wr_n`=0, `busy`=0 and the receiver is not locked out, `din` is accepted. From that edge on, `m_valid`=1 and the oldest unsent byte is on `m_data`. After reset, `busy`, `m_valid` and `abort` are all 0.
- R2: `busy` is 1 exactly when the buffer holds DEPTH bytes. It rises after the edge that stores the DEPTH-th byte and falls after the edge where the downstream side takes a byte (`m_valid`=1 and `m_ready`=1).
- R3: A byte on the bus while `busy`=1 is not stored. If the host holds it, it is stored once, at the first edge at which `busy` is 0.
- R4: An edge with `sel_n`=0 and `wr_n`=1 is a readback cycle and stores nothing.
- R5: While `sel_n`=1, the values on `din` and `wr_n` have no effect. `busy` changes only because the downstream side takes a byte.
- R6: If `sel_n` was 0 at the previous edge and is 0 again, and `wr_n` differs between the two edges, `abort` is 1 for the one cycle after that edge.
- R7: The edge that raises an abort stores no byte and empties the buffer. Right after that edge, `m_valid`=0 and `busy`=0.
- R8: After an abort, no byte is stored until an edge with `sel_n`=1 has been sampled. Write cycles after that edge are stored normally.
- R9: Bytes from successive select windows leave on `m_data` in the order they were accepted, with none lost or repeated.
- R10: While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1 and `m_data` stays the same, unless an abort empties the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; high with select low means readback |
| din | input | DATA_W | Write data from the host |
| busy | output | 1 | Registered flow-control flag; host holds data while high |
| m_valid | output | 1 | Downstream byte available |
| m_ready | input | 1 | Downstream sink takes the byte when high with `m_valid` |
| m_data | output | DATA_W | Oldest buffered byte |
| abort | output | 1 | One-cycle pulse on a write-level change inside a select window |

## Verification
Every result is due right after the rising edge that samples its cause, with no extra delay. A stored byte shows on `m_valid`/`m_data` after the accepting edge. `busy` follows the buffer fill after that same edge. The abort pulse, and the empty buffer that goes with it, appear after the edge at which the second select-low sample shows a different write level. The bench drives inputs on the falling edge and updates its reference model with the values that the next rising edge will sample. It then compares every output one time step after that rising edge, so each expected value is checked in the cycle it first becomes due.

// File: rtl/cfg_port_rx_pkg.sv
// Shared types for the configuration port receiver.
// Assumes active-low select and write strobes as seen on the pins.
package cfg_port_rx_pkg;

    // Kind of bus cycle seen at a sampling edge
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_WRITE = 2'd1,
        CYC_READ  = 2'd2
    } port_cyc_e;

    // Decode the raw strobes into a cycle kind
    function automatic port_cyc_e classify(input logic sel_n, input logic wr_n);
        if (sel_n)
            return CYC_IDLE;
        else if (!wr_n)
            return CYC_WRITE;
        else
            return CYC_READ;
    endfunction

endpackage

// File: rtl/cfg_port_sampler.sv
// Edge sampler and protocol checker for the host side of the port.
// Decides per edge whether the bus byte is stored, and detects a
// write-level change inside a select window (abort). Keeps a lockout
// after an abort until select has been seen released.
// Assumes: busy is the registered full flag from the buffer.
module cfg_port_sampler
    import cfg_port_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    input  logic              busy,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              abort_det
);

    port_cyc_e cyc;
    logic      prev_sel_act;
    logic      prev_wr_act;
    logic      locked;

    // Classify the cycle and find a write-level change within select
    always_comb begin
        cyc       = classify(sel_n, wr_n);
        abort_det = prev_sel_act && !sel_n && (prev_wr_act != !wr_n);
        push      = (cyc == CYC_WRITE) && !busy && !locked && !abort_det;
        push_data = din;
    end

    // Remember the previous sample of select and write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel_act <= 1'b0;
            prev_wr_act  <= 1'b0;
        end else begin
            prev_sel_act <= !sel_n;
            prev_wr_act  <= !wr_n;
        end
    end

    // Lockout: set on abort, cleared by an edge with select released
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (abort_det)
            locked <= 1'b1;
        else if (sel_n)
            locked <= 1'b0;
    end

endmodule

// File: rtl/cfg_port_fifo.sv
// Small synchronous byte buffer between the port and the downstream sink.
// Flush has priority over push and pop. Full is derived from a
// registered count, so it only changes at clock edges.
// Assumes: push is never requested while full.
module cfg_port_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              not_empty,
    output logic              full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push;
    logic              do_pop;

    // Qualify requests against the current fill level
    always_comb begin
        do_push   = push && (count != FULL_CNT);
        do_pop    = pop && (count != '0);
        head      = mem[rd_ptr];
        not_empty = (count != '0);
        full      = (count == FULL_CNT);
    end

    // Storage write; entries need no reset
    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_ptr] <= push_data;
    end

    // Pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cfg_port_rx.sv
// Target-side receiver for a byte-wide configuration port.
// Samples select, write and data on each rising edge, buffers written
// bytes, streams them out over valid/ready, backpressures the host with
// a registered busy flag and pulses abort on a write-level change inside
// a select window. Assumes the host holds data while busy is high.
module cfg_port_rx #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              abort
);

    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              abort_det;
    logic              pop;
    logic              full;
    logic              abort_q;

    cfg_port_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .din       (din),
        .busy      (full),
        .push      (push),
        .push_data (push_data),
        .abort_det (abort_det)
    );

    cfg_port_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (abort_det),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (m_data),
        .not_empty (m_valid),
        .full      (full)
    );

    // Downstream handshake completes when both sides agree
    always_comb pop = m_valid && m_ready;

    // Register the abort detection into a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            abort_q <= 1'b0;
        else
            abort_q <= abort_det;
    end

    assign abort = abort_q;
    assign busy  = full;

endmodule

// File: rtl/cfg_port_rx_chk.sv
// Protocol checker for cfg_port_rx, attached by bind.
module cfg_port_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              wr_n,
    input logic              busy,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              abort
);

    logic started;

    // Marks that one sampled edge has passed since reset release
    always_ff @(posedge clk) begin
        if (!rst_n)
            started <= 1'b0;
        else
            started <= 1'b1;
    end

    a_r2_busy_means_data: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> m_valid);

    a_r4_no_store_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_valid && (sel_n || wr_n)) |=> !m_valid);

    a_r5_busy_steady_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !(m_valid && m_ready)) |=> $stable(busy));

    a_r6_abort_on_level_change: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !sel_n && !$past(sel_n) && (wr_n != $past(wr_n))) |=> abort);

    a_r7_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (!m_valid && !busy));

    a_r10_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> ((m_valid && $stable(m_data)) || abort));

endmodule

bind cfg_port_rx cfg_port_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .wr_n    (wr_n),
    .busy    (busy),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .abort   (abort)
);

// File: tb/cfg_port_rx_tb.sv
// Self-checking bench: reference model plus directed and random phases.
module cfg_port_rx_tb;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic              busy;
    logic              m_valid;
    logic              m_ready = 1'b0;
    logic [DATA_W-1:0] m_data;
    logic              abort;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic [DATA_W-1:0] q[$];
    bit m_locked = 0;
    bit m_prev_sel = 0;
    bit m_prev_wr = 0;
    bit m_abort = 0;

    always #10 clk = ~clk;

    cfg_port_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .din(din),
        .busy(busy), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .abort(abort)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model of one sampling edge, applied with the pre-edge inputs
    function automatic void model_edge(input bit s_n, input bit w_n,
                                       input logic [DATA_W-1:0] d, input bit rdy);
        bit full_now = (q.size() == DEPTH);
        bit ab = m_prev_sel && !s_n && (m_prev_wr != !w_n);
        bit pop = (q.size() > 0) && rdy;
        bit psh = !s_n && !w_n && !full_now && !m_locked && !ab;
        if (ab) q.delete();
        else begin
            if (pop) void'(q.pop_front());
            if (psh) q.push_back(d);
        end
        if (ab) m_locked = 1;
        else if (s_n) m_locked = 0;
        m_prev_sel = !s_n;
        m_prev_wr  = !w_n;
        m_abort    = ab;
    endfunction

    // Drive one cycle, advance model, compare all outputs after the edge
    task automatic step(input bit s_n, input bit w_n, input logic [DATA_W-1:0] d,
                        input bit rdy, input string tag);
        @(negedge clk);
        sel_n = s_n; wr_n = w_n; din = d; m_ready = rdy;
        model_edge(s_n, w_n, d, rdy);
        @(posedge clk);
        #1;
        check(busy == (q.size() == DEPTH), {tag, " R2 busy"}, busy, q.size() == DEPTH);
        check(m_valid == (q.size() > 0), {tag, " R1 m_valid"}, m_valid, q.size() > 0);
        if (q.size() > 0)
            check(m_data == q[0], {tag, " R9 m_data"}, m_data, q[0]);
        check(abort == m_abort, {tag, " R6 abort"}, abort, m_abort);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7345));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(busy == 0, "R1 reset busy", busy, 0);
        check(m_valid == 0, "R1 reset m_valid", m_valid, 0);
        check(abort == 0, "R1 reset abort", abort, 0);

        // R1: single write
        step(0, 0, 8'hA5, 0, "R1");
        check(m_data == 8'hA5, "R1 first byte", m_data, 8'hA5);

        // R2 / R3: fill, then hold a byte while busy, then drain one
        step(0, 0, 8'h11, 0, "R2");
        step(0, 0, 8'h22, 0, "R2");
        step(0, 0, 8'h33, 0, "R2");
        check(busy == 1, "R2 full raises busy", busy, 1);
        step(0, 0, 8'h44, 0, "R3");
        step(0, 0, 8'h44, 0, "R3");
        check(m_data == 8'hA5, "R3 no store while busy", m_data, 8'hA5);
        step(0, 0, 8'h44, 1, "R3");
        check(busy == 0, "R2 pop clears busy", busy, 0);
        step(0, 0, 8'h44, 0, "R3");
        check(busy == 1, "R3 held byte taken once", busy, 1);

        // R5: select high with wr/din toggling, no pop
        for (int i = 0; i < 6; i++)
            step(1, i[0], 8'(i * 37), 0, "R5");
        check(busy == 1, "R5 busy unchanged", busy, 1);

        // Drain all
        for (int i = 0; i < 5; i++) step(1, 1, 8'h00, 1, "R9");

        // R4: readback cycles store nothing
        step(0, 1, 8'h5A, 0, "R4");
        step(0, 1, 8'h5B, 0, "R4");
        check(m_valid == 0, "R4 read stores nothing", m_valid, 0);

        // R6 / R8: read then write in one window gives abort, then lockout
        step(0, 0, 8'h61, 0, "R6");
        check(abort == 1, "R6 abort pulse", abort, 1);
        step(0, 0, 8'h62, 0, "R8");
        check(abort == 0, "R6 pulse one cycle", abort, 0);
        step(0, 0, 8'h63, 0, "R8");
        check(m_valid == 0, "R8 locked out", m_valid, 0);
        step(1, 1, 8'h00, 0, "R8");
        step(0, 0, 8'h64, 0, "R8");
        check(m_valid == 1 && m_data == 8'h64, "R8 resumes", m_data, 8'h64);

        // R7: buffered bytes then write->read change empties
        step(0, 0, 8'h65, 0, "R7");
        step(0, 1, 8'h66, 0, "R7");
        check(m_valid == 0 && busy == 0, "R7 flushed", m_valid, 0);
        step(1, 1, 8'h00, 0, "R7");

        // R9 / R10: bytes across select gaps, output held while not ready
        step(0, 0, 8'h71, 0, "R9");
        step(1, 0, 8'hFF, 0, "R9");
        step(0, 0, 8'h72, 0, "R9");
        step(1, 1, 8'hEE, 0, "R10");
        check(m_data == 8'h71, "R10 held head", m_data, 8'h71);
        step(1, 1, 8'h00, 1, "R9");
        check(m_data == 8'h72, "R9 order across gap", m_data, 8'h72);
        step(1, 1, 8'h00, 1, "R9");

        // Random phase
        begin
            bit s = 1, w = 0;
            for (int i = 0; i < 4000; i++) begin
                s = ($urandom_range(99) < 30);
                if ($urandom_range(99) < 6) w = !w;
                step(s, w, 8'($urandom), $urandom_range(1) == 1, "R9 rand");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule